// File: doc/BRIEF.md
# Display Power-On Reset Sequencer

This block takes a small display controller from power-up to a known running state. One start strobe switches on the supply enable. The block then pulses the controller's active-low reset pin, if the board has one. It sends the controller a software reset command over a byte-wide command link, and it waits out the settling time the controller needs before it finishes. It reports through three sticky result flags and a one-cycle done strobe.

In conditional mode the block first reads the controller's power-mode byte over the same link. If the display is already up, no reset is needed. This avoids the visible flicker a fresh reset would cause after an earlier stage has already brought the panel up. All delays are counted on a one-microsecond tick that comes from outside the block, so the block does not depend on the system clock rate.

A failed software reset command drops the supply enable again and ends the sequence with the error result.

Top module: `disp_pwron_seq`

## Requirements
- R1: During and directly after reset: `lcd_rst_n_o`=1, `reg_en_o`=0, `cmd_valid_o`=0, `done_o`=0, and all three result flags are 0.
- R2: On an accepted `start_i`, `reg_en_o` rises at least one cycle before any other activity. Other activity means the reset pin going low or any command strobe. `reg_en_o` stays high whenever the reset pin is low or a command is strobed.
- R3: When `hw_rst_present_i`=1, `lcd_rst_n_o` is held low for HOLD_US ticks, with one extra tick allowed. It is then high for SETTLE_US ticks, again with one extra tick allowed, before the software reset command code 0x01 is strobed. Each command is a single-cycle strobe.
- R4: When `hw_rst_present_i`=0, `lcd_rst_n_o` never goes low. The software reset command 0x01 is the first command of a non-conditional sequence.
- R5: After the software reset command completes without error, the block waits SHORT_US ticks if a reset line is present and LONG_US ticks if not, with one extra tick allowed in each case. It then raises `done_o` with `did_reset_o`=1.
- R6: With `cond_i`=1, the first command is the power-mode read, code 0x0A, strobed with `cmd_rd_o`=1. If the returned byte ANDed with 0x7C equals 0x1C, meaning bits 2, 3 and 4 are set and bits 5 and 6 are clear, the sequence ends with `already_on_o`=1. In that case no reset pulse and no software reset command are issued.
- R7: Bits 0, 1 and 7 of the power-mode byte have no effect on the decision. 0x9F counts as on. 0x0C counts as off and leads to the full reset sequence.
- R8: If the power-mode read returns `cmd_err_i`=1, the display is treated as off and the full reset sequence runs.
- R9: If the software reset command returns `cmd_err_i`=1, `reg_en_o` is cleared and the sequence ends with `error_o`=1 and `did_reset_o`=0.
- R10: `done_o` is a one-cycle pulse. Exactly one result flag is set when it fires. The flags hold their values until the next accepted start, which clears them.
- R11: `start_i` is ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| cond_i | input | 1 | Conditional mode: read the power mode first |
| hw_rst_present_i | input | 1 | Board has a hardware reset line |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| cmd_valid_o | output | 1 | Command strobe towards the link |
| cmd_rd_o | output | 1 | Strobed command expects one read byte |
| cmd_byte_o | output | 8 | Command code |
| cmd_done_i | input | 1 | Link finished the command |
| cmd_err_i | input | 1 | Link reports failure, valid with done |
| cmd_rdata_i | input | 8 | Byte read back, valid with done |
| lcd_rst_n_o | output | 1 | Active-low controller reset pin |
| reg_en_o | output | 1 | Supply regulator enable |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| did_reset_o | output | 1 | Result: controller was reset |
| already_on_o | output | 1 | Result: display found running, reset skipped |
| error_o | output | 1 | Result: software reset command failed |

## Verification
The supply enable appears one cycle after the accepted start, and the first command strobe or reset-pin fall comes at least one cycle after that. The bench records the cycle of each event and compares the order.

Delays are checked in ticks rather than cycles. In every cycle, the bench drives the tick and the link handshake first and only then looks at the outputs. Each tick is therefore credited to the phase the design is in when it consumes that tick. The counts for the low pulse, the settle time and the post-command wait must each equal the parameter or exceed it by one tick.

The link model answers each command two cycles after its strobe. The done strobe and result flags are due in the cycle after the last wait runs out. They are captured in that cycle and read again a few cycles later to confirm they hold.

// File: rtl/disp_pwron_pkg.sv
package disp_pwron_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_POWER,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_RST_LOW,
      ST_RST_SETTLE,
      ST_SWR_REQ,
      ST_SWR_WAIT,
      ST_POST,
      ST_FINISH
   } seq_state_t;

   localparam logic [7:0] CMD_SOFT_RESET  = 8'h01;
   localparam logic [7:0] CMD_READ_PWR    = 8'h0A;
   // power-mode bits 0, 1 and 7 are reserved and excluded from the compare
   localparam logic [7:0] PWR_IGNORE_MASK = 8'h83;
   // bits 2, 3, 4: display on, normal mode, out of sleep
   localparam logic [7:0] PWR_ON_PATTERN  = 8'h1C;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/disp_pwron_timer.sv
module disp_pwron_timer #(
   parameter int unsigned TW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   input  logic          tick_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (load_i)                   cnt_q <= val_i;
      else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/disp_pwron_decode.sv
module disp_pwron_decode
   import disp_pwron_pkg::*;
(
   input  logic [7:0] pm_i,
   output logic       on_o
);

   assign on_o = ((pm_i & ~PWR_IGNORE_MASK) == PWR_ON_PATTERN);

endmodule

// File: rtl/disp_pwron_fsm.sv
module disp_pwron_fsm
   import disp_pwron_pkg::*;
#(
   parameter int unsigned TW        = 17,
   parameter int unsigned HOLD_US   = 20,
   parameter int unsigned SETTLE_US = 120000,
   parameter int unsigned SHORT_US  = 5000,
   parameter int unsigned LONG_US   = 120000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          cond_i,
   input  logic          hw_line_i,
   input  logic          disp_on_i,
   input  logic          cmd_done_i,
   input  logic          cmd_err_i,
   input  logic          tmr_zero_i,
   output logic          tmr_load_o,
   output logic [TW-1:0] tmr_val_o,
   output logic          cmd_valid_o,
   output logic          cmd_rd_o,
   output logic [7:0]    cmd_byte_o,
   output logic          lcd_rst_n_o,
   output logic          reg_en_o,
   output logic          done_o,
   output logic          did_reset_o,
   output logic          already_on_o,
   output logic          error_o
);

   localparam logic [TW-1:0] T_HOLD   = TW'(HOLD_US);
   localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_US);
   localparam logic [TW-1:0] T_SHORT  = TW'(SHORT_US);
   localparam logic [TW-1:0] T_LONG   = TW'(LONG_US);

   seq_state_t state_q, state_d;
   logic       hw_q, cond_q;

   always_comb begin
      state_d    = state_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      unique case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_POWER;
         ST_POWER: begin
            if (cond_q) state_d = ST_RD_REQ;
            else if (hw_q) begin
               state_d    = ST_RST_LOW;
               tmr_load_o = 1'b1;
               tmr_val_o  = T_HOLD;
            end else state_d = ST_SWR_REQ;
         end
         ST_RD_REQ:  state_d = ST_RD_WAIT;
         ST_RD_WAIT: begin
            if (cmd_done_i) begin
               if (!cmd_err_i && disp_on_i) state_d = ST_FINISH;
               else if (hw_q) begin
                  state_d    = ST_RST_LOW;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = T_HOLD;
               end else state_d = ST_SWR_REQ;
            end
         end
         ST_RST_LOW: begin
            if (tmr_zero_i) begin
               state_d    = ST_RST_SETTLE;
               tmr_load_o = 1'b1;
               tmr_val_o  = T_SETTLE;
            end
         end
         ST_RST_SETTLE: if (tmr_zero_i) state_d = ST_SWR_REQ;
         ST_SWR_REQ:    state_d = ST_SWR_WAIT;
         ST_SWR_WAIT: begin
            if (cmd_done_i) begin
               if (cmd_err_i) state_d = ST_FINISH;
               else begin
                  state_d    = ST_POST;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = hw_q ? T_SHORT : T_LONG;
               end
            end
         end
         ST_POST:   if (tmr_zero_i) state_d = ST_FINISH;
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         hw_q         <= 1'b0;
         cond_q       <= 1'b0;
         reg_en_o     <= 1'b0;
         did_reset_o  <= 1'b0;
         already_on_o <= 1'b0;
         error_o      <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            hw_q         <= hw_line_i;
            cond_q       <= cond_i;
            reg_en_o     <= 1'b1;
            did_reset_o  <= 1'b0;
            already_on_o <= 1'b0;
            error_o      <= 1'b0;
         end
         if (state_q == ST_RD_WAIT && cmd_done_i && !cmd_err_i && disp_on_i)
            already_on_o <= 1'b1;
         if (state_q == ST_SWR_WAIT && cmd_done_i && cmd_err_i) begin
            reg_en_o <= 1'b0;
            error_o  <= 1'b1;
         end
         if (state_q == ST_POST && tmr_zero_i)
            did_reset_o <= 1'b1;
      end
   end

   assign cmd_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_SWR_REQ);
   assign cmd_rd_o    = (state_q == ST_RD_REQ);
   assign cmd_byte_o  = (state_q == ST_RD_REQ)  ? CMD_READ_PWR :
                        (state_q == ST_SWR_REQ) ? CMD_SOFT_RESET : 8'h00;
   assign lcd_rst_n_o = (state_q != ST_RST_LOW);
   assign done_o      = (state_q == ST_FINISH);

endmodule

// File: rtl/disp_pwron_seq.sv
module disp_pwron_seq
   import disp_pwron_pkg::*;
#(
   parameter int unsigned HOLD_US   = 20,
   parameter int unsigned SETTLE_US = 120000,
   parameter int unsigned SHORT_US  = 5000,
   parameter int unsigned LONG_US   = 120000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       cond_i,
   input  logic       hw_rst_present_i,
   input  logic       us_tick_i,
   output logic       cmd_valid_o,
   output logic       cmd_rd_o,
   output logic [7:0] cmd_byte_o,
   input  logic       cmd_done_i,
   input  logic       cmd_err_i,
   input  logic [7:0] cmd_rdata_i,
   output logic       lcd_rst_n_o,
   output logic       reg_en_o,
   output logic       done_o,
   output logic       did_reset_o,
   output logic       already_on_o,
   output logic       error_o
);

   localparam int unsigned MAX_US = max_u(max_u(HOLD_US, SETTLE_US), max_u(SHORT_US, LONG_US));
   localparam int unsigned TW     = $clog2(MAX_US + 1);

   if (HOLD_US == 0 || SETTLE_US == 0 || SHORT_US == 0 || LONG_US == 0) begin : g_bad_wait
      $error("disp_pwron_seq: every wait must be at least one tick");
   end
   if (SHORT_US > LONG_US) begin : g_bad_order
      $error("disp_pwron_seq: the wait after a pin reset must not exceed the blind wait");
   end

   logic          tmr_load, tmr_zero, disp_on;
   logic [TW-1:0] tmr_val;

   disp_pwron_decode u_decode (
      .pm_i (cmd_rdata_i),
      .on_o (disp_on)
   );

   disp_pwron_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .tick_i (us_tick_i),
      .zero_o (tmr_zero)
   );

   disp_pwron_fsm #(
      .TW(TW), .HOLD_US(HOLD_US), .SETTLE_US(SETTLE_US),
      .SHORT_US(SHORT_US), .LONG_US(LONG_US)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .cond_i       (cond_i),
      .hw_line_i    (hw_rst_present_i),
      .disp_on_i    (disp_on),
      .cmd_done_i   (cmd_done_i),
      .cmd_err_i    (cmd_err_i),
      .tmr_zero_i   (tmr_zero),
      .tmr_load_o   (tmr_load),
      .tmr_val_o    (tmr_val),
      .cmd_valid_o  (cmd_valid_o),
      .cmd_rd_o     (cmd_rd_o),
      .cmd_byte_o   (cmd_byte_o),
      .lcd_rst_n_o  (lcd_rst_n_o),
      .reg_en_o     (reg_en_o),
      .done_o       (done_o),
      .did_reset_o  (did_reset_o),
      .already_on_o (already_on_o),
      .error_o      (error_o)
   );

endmodule

// File: rtl/disp_pwron_chk.sv
module disp_pwron_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       hw_rst_present_i,
   input logic       cmd_valid_o,
   input logic       cmd_rd_o,
   input logic [7:0] cmd_byte_o,
   input logic       lcd_rst_n_o,
   input logic       reg_en_o,
   input logic       done_o,
   input logic       did_reset_o,
   input logic       already_on_o,
   input logic       error_o
);

   assert_reg_before_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_rst_n_o |-> reg_en_o);

   assert_reg_before_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> reg_en_o);

   assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   assert_no_line_no_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_rst_present_i |-> lcd_rst_n_o);

   assert_read_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rd_o |-> (cmd_valid_o && cmd_byte_o == 8'h0A));

   assert_err_drops_supply_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && error_o) |-> !reg_en_o);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones({did_reset_o, already_on_o, error_o}) == 1));

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && !$past(start_i)) |-> $stable({did_reset_o, already_on_o, error_o}));

endmodule

bind disp_pwron_seq disp_pwron_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .start_i          (start_i),
   .hw_rst_present_i (hw_rst_present_i),
   .cmd_valid_o      (cmd_valid_o),
   .cmd_rd_o         (cmd_rd_o),
   .cmd_byte_o       (cmd_byte_o),
   .lcd_rst_n_o      (lcd_rst_n_o),
   .reg_en_o         (reg_en_o),
   .done_o           (done_o),
   .did_reset_o      (did_reset_o),
   .already_on_o     (already_on_o),
   .error_o          (error_o)
);

// File: tb/disp_pwron_seq_tb.sv
module disp_pwron_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int P_HOLD     = 3;
   localparam int P_SETTLE   = 10;
   localparam int P_SHORT    = 5;
   localparam int P_LONG     = 12;

   logic       clk, rst_n, start_i, cond_i, hw_rst_present_i, us_tick_i;
   logic       cmd_valid_o, cmd_rd_o, cmd_done_i, cmd_err_i;
   logic [7:0] cmd_byte_o, cmd_rdata_i;
   logic       lcd_rst_n_o, reg_en_o, done_o, did_reset_o, already_on_o, error_o;

   disp_pwron_seq #(
      .HOLD_US(P_HOLD), .SETTLE_US(P_SETTLE), .SHORT_US(P_SHORT), .LONG_US(P_LONG)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cond_i(cond_i),
      .hw_rst_present_i(hw_rst_present_i), .us_tick_i(us_tick_i),
      .cmd_valid_o(cmd_valid_o), .cmd_rd_o(cmd_rd_o), .cmd_byte_o(cmd_byte_o),
      .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i), .cmd_rdata_i(cmd_rdata_i),
      .lcd_rst_n_o(lcd_rst_n_o), .reg_en_o(reg_en_o), .done_o(done_o),
      .did_reset_o(did_reset_o), .already_on_o(already_on_o), .error_o(error_o)
   );

   int n_checks = 0;
   int n_errors = 0;

   // link model configuration and event log
   logic [7:0] cfg_rdata;
   logic       cfg_rd_err, cfg_sw_err;
   int         cyc = 0;
   int         resp_cnt;
   logic [7:0] pend_byte;
   int         n_cmd, n_done;
   logic [7:0] cmd_log [0:7];
   int         t_low, t_settle, t_post;
   bit         seen_fall, seen_swcmd, seen_ack;
   int         reg_rise_cyc, first_act_cyc;
   logic       res_did, res_on, res_err, res_reg;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      resp_cnt = 0; n_cmd = 0; n_done = 0;
      t_low = 0; t_settle = 0; t_post = 0;
      seen_fall = 0; seen_swcmd = 0; seen_ack = 0;
      reg_rise_cyc = -1; first_act_cyc = -1;
      res_did = 0; res_on = 0; res_err = 0; res_reg = 0;
      for (int i = 0; i < 8; i++) cmd_log[i] = 8'h00;
   endtask

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // per-cycle driver of tick and link, then observer of outputs
   initial begin
      bit ack_now;
      us_tick_i = 0; cmd_done_i = 0; cmd_err_i = 0; cmd_rdata_i = 8'h00;
      forever begin
         @(negedge clk);
         cyc++;
         ack_now    = 0;
         us_tick_i  = (cyc % TICK_DIV) == 0;
         cmd_done_i = 1'b0;
         cmd_err_i  = 1'b0;
         if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
               cmd_done_i = 1'b1;
               if (pend_byte == 8'h0A) begin
                  cmd_rdata_i = cfg_rdata;
                  cmd_err_i   = cfg_rd_err;
               end else begin
                  cmd_err_i = cfg_sw_err;
                  ack_now   = 1;
               end
            end
         end
         if (rst_n) begin
            if (reg_en_o && reg_rise_cyc < 0) reg_rise_cyc = cyc;
            if (cmd_valid_o) begin
               if (n_cmd < 8) cmd_log[n_cmd] = cmd_byte_o;
               n_cmd++;
               pend_byte = cmd_byte_o;
               resp_cnt  = 2;
               if (cmd_byte_o == 8'h01) seen_swcmd = 1;
               if (first_act_cyc < 0) first_act_cyc = cyc;
            end
            if (!lcd_rst_n_o) begin
               seen_fall = 1;
               if (first_act_cyc < 0) first_act_cyc = cyc;
               t_low += int'(us_tick_i);
            end else if (seen_fall && !seen_swcmd) begin
               t_settle += int'(us_tick_i);
            end
            if (seen_ack && !done_o) t_post += int'(us_tick_i);
            if (done_o) begin
               n_done++;
               res_did = did_reset_o; res_on = already_on_o;
               res_err = error_o;     res_reg = reg_en_o;
            end
            if (ack_now && !cmd_err_i) seen_ack = 1;
         end
      end
   end

   task automatic run_seq(input bit cond, input bit hw, input int restart_at);
      int k;
      clear_log();
      cond_i = cond;
      hw_rst_present_i = hw;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      k = 0;
      while (n_done == 0 && k < 3000) begin
         @(negedge clk);
         k++;
         start_i = (restart_at > 0 && k == restart_at);
      end
      start_i = 1'b0;
      check(k < 3000, "R10", "sequence finished", k, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic test_reset_state();
      check(lcd_rst_n_o === 1'b1 && reg_en_o === 1'b0, "R1", "pin/supply after reset",
            {lcd_rst_n_o, reg_en_o}, 2);
      check(cmd_valid_o === 1'b0 && done_o === 1'b0, "R1", "strobes after reset",
            {cmd_valid_o, done_o}, 0);
      check({did_reset_o, already_on_o, error_o} === 3'b000, "R1", "results after reset",
            {did_reset_o, already_on_o, error_o}, 0);
   endtask

   task automatic test_pin_reset();
      cfg_sw_err = 0;
      run_seq(0, 1, 0);
      check(reg_rise_cyc >= 0 && reg_rise_cyc < first_act_cyc, "R2", "supply before activity",
            reg_rise_cyc, first_act_cyc - 1);
      check(t_low == P_HOLD || t_low == P_HOLD + 1, "R3", "low ticks", t_low, P_HOLD);
      check(t_settle == P_SETTLE || t_settle == P_SETTLE + 1, "R3", "settle ticks",
            t_settle, P_SETTLE);
      check(n_cmd == 1 && cmd_log[0] == 8'h01, "R3", "soft reset command", cmd_log[0], 1);
      check(t_post == P_SHORT || t_post == P_SHORT + 1, "R5", "short wait ticks", t_post, P_SHORT);
      check(res_did && !res_on && !res_err, "R5", "did_reset result",
            {res_did, res_on, res_err}, 4);
      check(n_done == 1 && done_o === 1'b0, "R10", "single done pulse", n_done, 1);
      check(did_reset_o === 1'b1, "R10", "result held", did_reset_o, 1);
   endtask

   task automatic test_no_line();
      cfg_sw_err = 0;
      run_seq(0, 0, 0);
      check(!seen_fall, "R4", "pin stays high", seen_fall, 0);
      check(n_cmd == 1 && cmd_log[0] == 8'h01, "R4", "first command", cmd_log[0], 1);
      check(t_post == P_LONG || t_post == P_LONG + 1, "R5", "long wait ticks", t_post, P_LONG);
      check(res_did, "R5", "did_reset without line", res_did, 1);
   endtask

   task automatic test_cond(input logic [7:0] pm, input bit rd_err, input bit expect_on,
                            input string req);
      cfg_rdata = pm; cfg_rd_err = rd_err; cfg_sw_err = 0;
      run_seq(1, 1, 0);
      check(cmd_log[0] == 8'h0A, "R6", "first command is read", cmd_log[0], 8'h0A);
      if (expect_on) begin
         check(res_on && !res_did && n_cmd == 1 && !seen_fall, req, "already on, no reset",
               {res_on, res_did, seen_fall}, 4);
         check(already_on_o === 1'b1 && did_reset_o === 1'b0, "R10",
               "flags cleared and held", {already_on_o, did_reset_o}, 2);
      end else begin
         check(res_did && !res_on && seen_fall && n_cmd == 2 && cmd_log[1] == 8'h01, req,
               "full reset taken", {res_did, res_on, seen_fall}, 5);
      end
   endtask

   task automatic test_sw_fail();
      cfg_sw_err = 1;
      run_seq(0, 1, 0);
      check(res_err && !res_did && !res_on, "R9", "error result",
            {res_err, res_did, res_on}, 4);
      check(res_reg == 1'b0 && reg_en_o === 1'b0, "R9", "supply dropped", reg_en_o, 0);
      cfg_sw_err = 0;
   endtask

   task automatic test_busy_start();
      cfg_sw_err = 0;
      run_seq(0, 1, 6);
      repeat (60) @(negedge clk);
      check(n_done == 1 && n_cmd == 1, "R11", "restart ignored", n_done * 10 + n_cmd, 11);
      check(done_o === 1'b0 && did_reset_o === 1'b1, "R11", "idle after ignored start",
            {done_o, did_reset_o}, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst_n = 0; start_i = 0; cond_i = 0; hw_rst_present_i = 1;
      cfg_rdata = 8'h00; cfg_rd_err = 0; cfg_sw_err = 0;
      clear_log();
      repeat (4) @(negedge clk);
      test_reset_state();
      rst_n = 1;
      @(negedge clk);
      test_reset_state();
      test_pin_reset();
      test_no_line();
      test_cond(8'h1C, 0, 1, "R6");
      test_cond(8'h9F, 0, 1, "R7");
      test_cond(8'h0C, 0, 0, "R7");
      test_cond(8'h1C, 1, 0, "R8");
      test_sw_fail();
      test_busy_start();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule